// File: doc/BRIEF.md
# Bang-Bang Settling Assist Controller

This block helps a digital phase-locked loop settle quickly while its phase detector is in single-bit (early/late) mode. On every reference-cycle sample of the detector sign it produces a signed frequency correction word. That word is added to the oscillator tuning path alongside the main loop filter's output. The correction has two parts. A derivative kick fires whenever the detector sign reverses, and its size shrinks with every reversal. An auxiliary integrator builds up while the sign keeps repeating, which pulls the frequency along during long one-sided runs.

A mode sequencer raises `en` when the loop enters single-bit detection. The gain is then loaded from `kd_init`. After enough reversals the gain reaches zero, the correction is held at zero and `done` is raised, so the assist drops out of the loop and cannot cause chattering once the loop is locked. Lowering `en` returns everything to its idle state.

Top module: `bbpid_assist_fsm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is idle after that edge: `corr_out` is 0 and `done` is 0.
- R2: In the first enabled cycle the gain is taken from `kd_init`, so the first reversal after entry drives `corr_out` to a magnitude equal to `kd_init`.
- R3: A valid sample whose sign differs from the stored sign is a reversal. One cycle later `corr_out` equals +gain when `pd_early` is 1, or -gain when it is 0.
- R4: Each reversal halves the gain with a right shift by one (1 becomes 0), so successive kicks are kd_init, kd_init>>1, kd_init>>2, and so on.
- R5: A valid sample with the same sign as the stored one adds `ki_gain` (for sign 1) or subtracts it (for sign 0) from the auxiliary integrator. One cycle later `corr_out` equals the new integrator value.
- R6: A reversal clears the auxiliary integrator, so the first repeat after a reversal gives exactly +/-`ki_gain`.
- R7: The integrator and `corr_out` saturate at the signed 16-bit limits, 32767 and -32768.
- R8: In the cycle after the gain is zero (after the reversal that zeroed it, or at entry with `kd_init` = 0), `done` rises and `corr_out` becomes 0. Both stay that way, ignoring samples, until `en` falls.
- R9: Lowering `en` clears all state, including `done`, on the next edge. Raising it again reloads `kd_init`.
- R10: The stored sign starts as positive (1) on entry. A first sample of 1 is therefore a repeat, and a first sample of 0 is a reversal.
- R11: A cycle with `pd_valid` low leaves `corr_out` and the internal state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Assist enable from the mode sequencer |
| pd_valid | input | 1 | Detector sample strobe, one per reference cycle |
| pd_early | input | 1 | Detector sign: 1 asks for positive correction, 0 for negative |
| kd_init | input | KD_W (12) | Initial derivative gain loaded on entry |
| ki_gain | input | KI_W (8) | Auxiliary integrator step |
| corr_out | output | CORR_W (16) | Signed correction word, two's complement |
| done | output | 1 | Gain has decayed to zero; assist removed |

## Verification
Directed alternating signs walk the gain through its full halving sequence down to `done`. This separates a correct shift from an off-by-one in the decrement or in when `done` appears. Long runs of one sign with the largest step push the integrator into both clamps, which exposes wrap-around. The first-sample cases with each sign, together with re-entry after `en` drops, show whether the stored sign and the gain are reloaded. Random stretches then mix reversals, repeats, idle strobes and enable drops, and are checked against a cycle model. This catches a stale integrator after a reversal and output movement on idle cycles.

// File: rtl/bbpid_pkg.sv
// Shared types for the bang-bang settling assist controller.
package bbpid_pkg;
    // Classification of a detector sample in the current cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,   // no sample acted on
        EV_FLIP = 2'd1,   // sign reversal
        EV_SAME = 2'd2    // sign repeated
    } bb_event_e;
endpackage

// File: rtl/bbpid_gain_decay.sv
// Derivative gain register.
// Loads kd_init in the first enabled cycle and halves on each shrink request.
// Assumes: shrink is only raised while the current gain is non-zero.
module bbpid_gain_decay #(
    parameter int KD_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [KD_W-1:0] kd_init,
    input  logic            shrink,
    output logic [KD_W-1:0] kd_cur,
    output logic            kd_zero
);
    logic            armed_q;
    logic [KD_W-1:0] kd_q;

    // Effective gain: the programmed value until the register has been loaded.
    always_comb begin
        kd_cur  = armed_q ? kd_q : kd_init;
        kd_zero = (kd_cur == '0);
    end

    // Gain storage: clear when disabled, otherwise hold or halve.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            armed_q <= 1'b0;
            kd_q    <= '0;
        end else begin
            armed_q <= 1'b1;
            kd_q    <= shrink ? (kd_cur >> 1) : kd_cur;
        end
    end

    // R4: every reversal leaves a strictly smaller gain
    a_r4_gain_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && shrink) |=> (kd_q < $past(kd_cur)));

    // R2: entry without a reversal captures the programmed gain
    a_r2_entry_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !armed_q && !shrink) |=> (kd_q == $past(kd_init)));
endmodule

// File: rtl/bbpid_aux_integ.sv
// Saturating auxiliary integrator.
// Adds or subtracts ki on each step and clamps to the signed CORR_W range.
// Assumes: KI_W < CORR_W; clr has priority over step.
module bbpid_aux_integ #(
    parameter int CORR_W = 16,
    parameter int KI_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     step,
    input  logic                     dir,
    input  logic [KI_W-1:0]          ki,
    output logic signed [CORR_W-1:0] acc_next,
    output logic signed [CORR_W-1:0] acc_q
);
    localparam int SUM_W = CORR_W + 1;
    localparam logic signed [CORR_W-1:0] ACC_MAX = {1'b0, {(CORR_W-1){1'b1}}};
    localparam logic signed [CORR_W-1:0] ACC_MIN = {1'b1, {(CORR_W-1){1'b0}}};

    logic signed [SUM_W-1:0] ki_ext;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;

    // Next value: widened add, then clamp on overflow of the top bit pair.
    always_comb begin
        ki_ext = signed'(SUM_W'(ki));
        delta  = dir ? ki_ext : -ki_ext;
        sum    = {acc_q[CORR_W-1], acc_q} + delta;
        if (!step)
            acc_next = acc_q;
        else if (sum[SUM_W-1] != sum[SUM_W-2])
            acc_next = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
        else
            acc_next = sum[CORR_W-1:0];
    end

    // Accumulator storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else
            acc_q <= acc_next;
    end

    // R7: positive clamp holds under further positive steps
    a_r7_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && dir && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));

    // R7: negative clamp holds under further negative steps
    a_r7_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && !dir && acc_q == ACC_MIN) |=> (acc_q == ACC_MIN));
endmodule

// File: rtl/bbpid_assist_fsm.sv
// Bang-bang settling assist controller (top).
// Classifies each detector sample as reversal or repeat, drives a derivative kick
// or the auxiliary integrator onto the correction word, and retires itself
// once the derivative gain has decayed to zero.
// Assumes: KD_W < CORR_W and KI_W < CORR_W.
module bbpid_assist_fsm
    import bbpid_pkg::*;
#(
    parameter int CORR_W = 16,
    parameter int KD_W   = 12,
    parameter int KI_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     pd_valid,
    input  logic                     pd_early,
    input  logic [KD_W-1:0]          kd_init,
    input  logic [KI_W-1:0]          ki_gain,
    output logic signed [CORR_W-1:0] corr_out,
    output logic                     done
);
    bb_event_e                ev;
    logic                     live;
    logic                     last_sign_q;
    logic                     done_q;
    logic signed [CORR_W-1:0] corr_q;
    logic [KD_W-1:0]          kd_cur;
    logic                     kd_zero;
    logic signed [CORR_W-1:0] kd_ext;
    logic signed [CORR_W-1:0] kick;
    logic signed [CORR_W-1:0] acc_next;
    logic signed [CORR_W-1:0] acc_q;

    // Sample classification against the stored sign.
    always_comb begin
        live = en && !done_q && !kd_zero && pd_valid;
        if (!live)
            ev = EV_NONE;
        else if (pd_early != last_sign_q)
            ev = EV_FLIP;
        else
            ev = EV_SAME;
    end

    // Derivative kick in the direction of the new sign.
    always_comb begin
        kd_ext = signed'(CORR_W'(kd_cur));
        kick   = pd_early ? kd_ext : -kd_ext;
    end

    bbpid_gain_decay #(.KD_W(KD_W)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .kd_init (kd_init),
        .shrink  (ev == EV_FLIP),
        .kd_cur  (kd_cur),
        .kd_zero (kd_zero)
    );

    bbpid_aux_integ #(.CORR_W(CORR_W), .KI_W(KI_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en || ev == EV_FLIP),
        .step     (ev == EV_SAME),
        .dir      (pd_early),
        .ki       (ki_gain),
        .acc_next (acc_next),
        .acc_q    (acc_q)
    );

    // Stored sign: positive on entry, follows every acted-on sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            last_sign_q <= 1'b1;
        else if (ev != EV_NONE)
            last_sign_q <= pd_early;
    end

    // Completion flag: set once the gain is zero, held until disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            done_q <= 1'b0;
        else if (kd_zero)
            done_q <= 1'b1;
    end

    // Correction word register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            corr_q <= '0;
        else if (done_q || kd_zero)
            corr_q <= '0;
        else begin
            case (ev)
                EV_FLIP: corr_q <= kick;
                EV_SAME: corr_q <= acc_next;
                default: corr_q <= corr_q;
            endcase
        end
    end

    assign corr_out = corr_q;
    assign done     = done_q;

    // R8: a retired controller contributes nothing
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (corr_q == '0));

    // R8: completion stays set while enabled
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && done_q) |=> done_q);

    // R9: disabling returns the outputs to idle
    a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (corr_q == '0 && !done_q));

    // R11: idle strobe leaves the correction untouched
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !done_q && !kd_zero && !pd_valid) |=> $stable(corr_q));

    // R3: the kick points the way of the new sign
    a_r3_kick_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_FLIP) |=> ($past(pd_early) ? (corr_q > 0) : (corr_q < 0)));
endmodule

// File: tb/sim_bbpid_assist_fsm.sv
module sim_bbpid_assist_fsm;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              pd_valid = 1'b0;
    logic              pd_early = 1'b0;
    logic [11:0]       kd_init = '0;
    logic [7:0]        ki_gain = '0;
    logic signed [15:0] corr_out;
    logic              done;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    bit    m_armed = 0;
    int    m_kd = 0;
    int    m_int = 0;
    bit    m_prev = 1;
    int    m_corr = 0;
    bit    m_done = 0;
    int    m_flips = 0;
    bit    m_after_flip = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    bbpid_assist_fsm u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pd_valid(pd_valid), .pd_early(pd_early),
        .kd_init(kd_init), .ki_gain(ki_gain), .corr_out(corr_out), .done(done)
    );

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_step(input bit e, input bit v, input bit s);
        int kdc;
        int raw;
        bit first;
        if (!rst_n || !e) begin
            m_armed = 0; m_kd = 0; m_int = 0; m_prev = 1; m_corr = 0; m_done = 0;
            m_flips = 0; m_after_flip = 0;
            tag = rst_n ? "R9" : "R1";
            return;
        end
        first = !m_armed;
        kdc = m_armed ? m_kd : int'(kd_init);
        m_armed = 1;
        if (m_done) begin
            tag = "R8";
        end else if (kdc == 0) begin
            m_done = 1; m_corr = 0; m_kd = 0; tag = "R8";
        end else if (!v) begin
            m_kd = kdc; tag = "R11";
        end else if (s != m_prev) begin
            m_corr = s ? kdc : -kdc;
            m_kd = kdc >> 1;
            m_int = 0;
            m_prev = s;
            tag = first ? "R10" : (m_flips == 0 ? "R2" : "R4");
            m_flips++;
            m_after_flip = 1;
        end else begin
            raw = m_int + (s ? int'(ki_gain) : -int'(ki_gain));
            m_int = clamp16(raw);
            m_corr = m_int;
            m_kd = kdc;
            if (raw != m_int) tag = "R7";
            else if (first) tag = "R10";
            else if (m_after_flip) tag = "R6";
            else tag = "R5";
            m_after_flip = 0;
        end
    endtask

    task automatic check_outputs();
        n_tests++;
        if (int'(corr_out) != m_corr || done != m_done) begin
            n_fail++;
            $display("FAIL %s: corr_out=%0d done=%0b expected corr_out=%0d done=%0b (t=%0t)",
                     tag, corr_out, done, m_corr, m_done, $time);
        end
    endtask

    // Drive one cycle at a falling edge, then check after the next falling edge.
    task automatic tick(input bit e, input bit v, input bit s);
        en = e; pd_valid = v; pd_early = s;
        model_step(e, v, s);
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(1, 1, 0);
        rst_n = 1'b1;
        tick(0, 0, 0);

        // R10/R5: first sample positive is a repeat; then R2, R4, R6 through decay to R8
        kd_init = 12'd100; ki_gain = 8'd5;
        tick(1, 1, 1);
        tick(1, 1, 1);
        tick(1, 1, 0);
        tick(1, 1, 0);
        tick(1, 0, 1);
        tick(1, 1, 1);
        for (int i = 0; i < 8; i++) tick(1, 1, (i % 2) == 0 ? 1'b0 : 1'b1);
        for (int i = 0; i < 4; i++) tick(1, 1, i[0]);

        // R9/R10: drop enable, re-enter with a negative first sample
        tick(0, 1, 0);
        kd_init = 12'd37;
        tick(1, 1, 0);
        tick(1, 1, 0);

        // R7: drive both clamps
        tick(0, 0, 0);
        kd_init = 12'd4095; ki_gain = 8'd255;
        for (int i = 0; i < 140; i++) tick(1, 1, 1);
        tick(1, 1, 0);
        for (int i = 0; i < 140; i++) tick(1, 1, 0);

        // R8: zero initial gain retires at once
        tick(0, 0, 0);
        kd_init = 12'd0;
        tick(1, 1, 0);
        tick(1, 1, 1);
        tick(1, 1, 0);

        // Random mix
        tick(0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            bit e;
            bit v;
            bit s;
            e = ($urandom % 64) != 0;
            if (!e || !en) begin
                kd_init = ($urandom % 2) ? 12'($urandom % 40) : 12'($urandom);
                ki_gain = 8'($urandom);
            end
            v = ($urandom % 4) != 0;
            s = (($urandom % 4) == 0) ? ~pd_early : pd_early;
            tick(e, v, s);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule